// File: doc/BRIEF.md
# J-K Entry Universal Shift Register

This block is a fully synchronous shift register of parameterised width, four bits by default. On each rising clock edge it either captures a parallel word or shifts its contents one place toward the highest stage. In shift mode the new value of stage 0 comes from a J-K style element whose K input is active low. That element can set, clear, toggle or hold the bit. Tying J and K together turns it into plain D-type serial entry.

The stored bits reach the outputs through a live polarity stage. When the true/complement input is high the outputs show the stored word unchanged. When it is low every output is inverted. This path is combinational and does not wait for a clock edge.

An active-high master clear empties the register at once, without waiting for the clock. While the clear is held, clock edges have no effect.

Top module: `jk_entry_shifter`

## Requirements
- R1: With load_en high (1 = load), a rising edge stores par_in, so bit i of par_in goes to stage i.
- R2: With load_en low (0 = shift), a rising edge moves each stage i to stage i+1, and the last stage's old value is lost.
- R3: In shift mode with j_in=1 and kn_in=1, stage 0 becomes 1.
- R4: In shift mode with j_in=0 and kn_in=0, stage 0 becomes 0.
- R5: In shift mode with j_in=1 and kn_in=0, stage 0 becomes the inverse of its previous stored value.
- R6: In shift mode with j_in=0 and kn_in=1, stage 0 keeps its previous stored value.
- R7: When j_in and kn_in are driven with the same serial bit, stage 0 takes that bit on each shift.
- R8: When true_pol is 1, q_out equals the stored word. When true_pol is 0, q_out is its bitwise inverse. A change of true_pol reaches q_out without a clock edge.
- R9: Raising clear empties every stage at once, without a clock edge. q_out then reads all zeros when true_pol=1 and all ones when true_pol=0.
- R10: Clock edges while clear is high change nothing. The first rising edge after clear falls acts normally.
- R11: The toggle and hold cases use the stored bit of stage 0, not the polarity-adjusted output, so they behave the same for either value of true_pol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Asynchronous active-high master clear |
| load_en | input | 1 | 1 = parallel load, 0 = shift |
| j_in | input | 1 | J input of the first stage |
| kn_in | input | 1 | Active-low K input of the first stage |
| par_in | input | W | Parallel word, bit i to stage i |
| true_pol | input | 1 | 1 = true outputs, 0 = complemented outputs |
| q_out | output | W | Polarity-adjusted stage contents |

## Verification
The clocked assertions assume that clear, load_en, j_in, kn_in and par_in change only between edges. They also assume that the register has seen at least one unreset edge before any past-value comparison, so they stay silent until then. The bench drives every input one nanosecond after a rising edge. It raises and lowers clear only in the middle of a cycle, so no input changes at the instant an edge samples it. The reset check is evaluated at falling edges, and clear is never toggled there.

// File: rtl/jks_pkg.sv
package jks_pkg;

    // stage-0 action, encoded as {j_in, kn_in}
    typedef enum logic [1:0] {
        ST0_CLEAR  = 2'b00,
        ST0_HOLD   = 2'b01,
        ST0_TOGGLE = 2'b10,
        ST0_SET    = 2'b11
    } st0_op_e;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_LOAD  = 1'b1
    } reg_mode_e;

    function automatic st0_op_e decode_jk(input logic j, input logic kn);
        return st0_op_e'({j, kn});
    endfunction

    function automatic logic stage0_next(input st0_op_e op, input logic cur);
        logic r;
        case (op)
            ST0_CLEAR:  r = 1'b0;
            ST0_HOLD:   r = cur;
            ST0_TOGGLE: r = ~cur;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jks_first_stage.sv
module jks_first_stage
    import jks_pkg::*;
(
    input  logic j,
    input  logic kn,
    input  logic cur,
    output logic nxt
);
    st0_op_e op;

    always_comb begin
        op  = decode_jk(j, kn);
        nxt = stage0_next(op, cur);
    end
endmodule

// File: rtl/jks_core.sv
module jks_core
    import jks_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear,
    input  reg_mode_e    mode,
    input  logic [W-1:0] par_in,
    input  logic         nxt0,
    output logic [W-1:0] state
);
    localparam int LAST = W - 1;

    logic [W-1:0] shifted;
    logic         armed;

    assign shifted[0] = nxt0;
    for (genvar i = 1; i <= LAST; i++) begin : g_shift
        assign shifted[i] = state[i-1];
    end

    always_ff @(posedge clk or posedge clear) begin
        if (clear) begin
            state <= '0;
            armed <= 1'b0;
        end else begin
            state <= (mode == MODE_LOAD) ? par_in : shifted;
            armed <= 1'b1;
        end
    end

    // R1
    load_capture_chk: assert property (@(posedge clk) disable iff (clear)
        (armed && mode == MODE_LOAD) |=> (state == $past(par_in)));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (clear)
        (armed && mode == MODE_SHIFT) |=> (state[LAST:1] == $past(state[LAST-1:0])));
endmodule

// File: rtl/jks_polarity.sv
module jks_polarity #(
    parameter int W = 4
) (
    input  logic         true_pol,
    input  logic [W-1:0] state,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_pol
        assign q[i] = true_pol ? state[i] : ~state[i];
    end
endmodule

// File: rtl/jk_entry_shifter.sv
module jk_entry_shifter
    import jks_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load_en,
    input  logic         j_in,
    input  logic         kn_in,
    input  logic [W-1:0] par_in,
    input  logic         true_pol,
    output logic [W-1:0] q_out
);
    logic [W-1:0] state;
    logic         nxt0;
    logic         seen;
    reg_mode_e    mode;

    assign mode = load_en ? MODE_LOAD : MODE_SHIFT;

    jks_first_stage u_first (
        .j   (j_in),
        .kn  (kn_in),
        .cur (state[0]),
        .nxt (nxt0)
    );

    jks_core #(.W(W)) u_core (
        .clk    (clk),
        .clear  (clear),
        .mode   (mode),
        .par_in (par_in),
        .nxt0   (nxt0),
        .state  (state)
    );

    jks_polarity #(.W(W)) u_pol (
        .true_pol (true_pol),
        .state    (state),
        .q        (q_out)
    );

    always_ff @(posedge clk or posedge clear) begin
        if (clear) seen <= 1'b0;
        else       seen <= 1'b1;
    end

    // R3
    st0_set_chk: assert property (@(posedge clk) disable iff (clear)
        (seen && !load_en && j_in && kn_in) |=> state[0]);

    // R4
    st0_clear_chk: assert property (@(posedge clk) disable iff (clear)
        (seen && !load_en && !j_in && !kn_in) |=> !state[0]);

    // R5
    st0_toggle_chk: assert property (@(posedge clk) disable iff (clear)
        (seen && !load_en && j_in && !kn_in) |=> (state[0] != $past(state[0])));

    // R6
    st0_hold_chk: assert property (@(posedge clk) disable iff (clear)
        (seen && !load_en && !j_in && kn_in) |=> $stable(state[0]));

    // R9
    always @(negedge clk) begin
        if (clear) begin
            reset_out_chk: assert (q_out == {W{~true_pol}});
        end
    end
endmodule

// File: tb/jk_entry_shifter_test.sv
`timescale 1ns/1ps
module jk_entry_shifter_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clear = 1'b1;
    logic         load_en = 1'b0;
    logic         j_in = 1'b0;
    logic         kn_in = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         true_pol = 1'b1;
    logic [W-1:0] q_out;

    logic [W-1:0] m = '0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    jk_entry_shifter #(.W(W)) uut (
        .clk(clk), .clear(clear), .load_en(load_en), .j_in(j_in),
        .kn_in(kn_in), .par_in(par_in), .true_pol(true_pol), .q_out(q_out)
    );

    function automatic logic [W-1:0] exp_out();
        return true_pol ? m : ~m;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // one rising edge; model follows the written behaviour
    task automatic tick();
        logic [W-1:0] nx;
        if (load_en) nx = par_in;
        else begin
            nx = {m[W-2:0], 1'b0};
            case ({j_in, kn_in})
                2'b11: nx[0] = 1'b1;
                2'b00: nx[0] = 1'b0;
                2'b10: nx[0] = ~m[0];
                default: nx[0] = m[0];
            endcase
        end
        @(posedge clk);
        if (!clear) m = nx;
        #1;
    endtask

    task automatic t_reset();
        #1;
        check("R9 reset state", q_out, 4'b0000);
        @(posedge clk); #1;
        clear = 1'b0;
        check("R9 reset state after release", q_out, 4'b0000);
    endtask

    task automatic t_load();
        logic [W-1:0] pats [4] = '{4'b1010, 4'b0101, 4'b1111, 4'b0011};
        foreach (pats[i]) begin
            load_en = 1'b1; par_in = pats[i];
            tick();
            check("R1 load", q_out, exp_out());
        end
    endtask

    task automatic t_shift_jk();
        load_en = 1'b1; par_in = 4'b0110; tick();
        load_en = 1'b0;
        j_in = 1; kn_in = 1; tick(); check("R3 set and R2 shift", q_out, exp_out());
        j_in = 0; kn_in = 0; tick(); check("R4 clear and R2 shift", q_out, exp_out());
        j_in = 1; kn_in = 0; tick(); check("R5 toggle from 0", q_out, exp_out());
        tick(); check("R5 toggle from 1", q_out, exp_out());
        j_in = 0; kn_in = 1; tick(); check("R6 hold", q_out, exp_out());
        tick(); check("R2 shift drops last stage", q_out, exp_out());
    endtask

    task automatic t_dtie();
        logic [7:0] ser = 8'b1011_0010;
        load_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            j_in = ser[i]; kn_in = ser[i];
            tick();
            check("R7 D-type entry", q_out, exp_out());
        end
    endtask

    task automatic t_polarity();
        load_en = 1'b1; par_in = 4'b1001; tick();
        load_en = 1'b0; j_in = 0; kn_in = 1;
        true_pol = 1'b0; #0.5;
        check("R8 complement without clock", q_out, 4'b0110);
        true_pol = 1'b1; #0.5;
        check("R8 true without clock", q_out, 4'b1001);
    endtask

    task automatic t_toggle_inverted();
        load_en = 1'b1; par_in = 4'b0001; tick();
        true_pol = 1'b0; load_en = 1'b0; j_in = 1; kn_in = 0;
        tick(); check("R11 toggle uses stored bit", q_out, exp_out());
        tick(); check("R11 toggle uses stored bit again", q_out, exp_out());
        j_in = 0; kn_in = 1;
        tick(); check("R11 hold uses stored bit", q_out, exp_out());
        true_pol = 1'b1;
    endtask

    task automatic t_async_reset();
        load_en = 1'b1; par_in = 4'b1101; tick();
        clear = 1'b1; m = '0; #0.5;
        check("R9 async clear true", q_out, 4'b0000);
        true_pol = 1'b0; #0.5;
        check("R9 async clear complement", q_out, 4'b1111);
        par_in = 4'b1111;
        tick(); tick();
        check("R10 edges ignored in clear", q_out, 4'b1111);
        true_pol = 1'b1; #0.5;
        clear = 1'b0;
        par_in = 4'b1010;
        tick();
        check("R10 first edge after release", q_out, 4'b1010);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_shift_jk();
        t_dtie();
        t_polarity();
        t_toggle_inverted();
        t_async_reset();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule